// File: doc/BRIEF.md
# SDRAM Refresh-Aware Command Sequencer

This block sits between a single client and one SDRAM device. It turns each read or write request into the device's command cycles on the four active-low control pins, together with a bank select and a multiplexed address bus. Every access is closed. The sequencer opens the row, waits the row-to-column delay, and then issues the column command with auto-precharge. It then keeps the bus quiet until the precharge, together with any write recovery, has completed. The device is then back in its all-banks-idle state. Device initialisation and mode programming take place before this block runs. The data pins are handled elsewhere.

A refresh pacer counts clocks and owes one auto-refresh for every elapsed refresh interval. The interval is set in picoseconds and is converted to clocks by rounding up. When the bus is idle and no request is waiting, owed refreshes go out at once. A waiting request may postpone them, but only up to a limit. Once the owed count reaches that limit, refresh wins and requests are held off.

The request side uses valid/ready. `req_ready` depends only on internal state and never on `req_valid`. A request is taken on a clock edge where both are high. From that edge until the sequencer is idle again, `req_ready` stays low. The client must hold `req_valid` and the request fields stable while `req_ready` is low.

Top module: `sdr_cmd_seq`

## Requirements
- R1: Commands are encoded on {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} as NOP = 0111, ACT = 0011, READ = 0101, WRIT = 0100 and REF = 0001, and NOP is driven in every cycle without a command. No other code ever appears.
- R2: A request accepted while idle produces an ACT in the next cycle, carrying the request bank on cmd_ba and the row on cmd_addr. req_ready is low from that cycle until the sequencer is idle again, and whenever req_ready is high the pins show NOP.
- R3: The READ (req_write = 0) or WRIT (req_write = 1) follows exactly T_RCD cycles after the ACT, to the same bank. cmd_addr carries the column in its low COL_W bits, bit 10 is high to select auto-precharge, and all other bits are 0.
- R4: After a READ, the next non-NOP command comes no earlier than RD_GAP = max(T_RAS - T_RCD, BURST_LEN) + T_RP cycles later, and req_ready returns high RD_GAP - 1 cycles after the READ (7 and 6 with the defaults).
- R5: After a WRIT, the gap is WR_GAP = max(T_RAS - T_RCD, BURST_LEN - 1 + T_DPL) + T_RP cycles, with req_ready high again WR_GAP - 1 cycles after the WRIT (8 and 7 with the defaults).
- R6: The refresh interval is ceil(REF_INTERVAL_PS / CLK_PERIOD_PS) clocks. The default of 15,625,000 ps is 64 ms over 4096 refreshes.
- R7: REF is issued only from idle, and it is followed by NOP for T_RC - 1 cycles. Back-to-back refreshes are therefore spaced exactly T_RC cycles apart.
- R8: With no request waiting, an owed refresh is issued from idle without delay, so an idle bus shows REF commands exactly one interval apart.
- R9: While a request is valid and fewer than MAX_OWED refreshes are owed, the access goes first. Once requests stop, all owed refreshes are issued back to back.
- R10: When MAX_OWED (default 8) refreshes are owed, req_ready drops and a REF is issued from idle even though a request is waiting.
- R11: After reset the pins show NOP, req_ready is high and no refresh is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Burst start column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank select |
| cmd_addr | output | ROW_W | Multiplexed address; bit 10 marks auto-precharge |

## Verification
The bound checker watches every cycle. It checks the command code set, the exact ACT-to-column spacing and the auto-precharge bit. It checks the read and write recovery gaps before the next ACT or REF, and the quiet window after each refresh. It also checks that an idle, ready sequencer drives NOP. The refresh interval and its rounding, the postponement of refresh behind a stream of requests, the burst of owed refreshes that follows it, and the forced refresh at the owed limit depend on long histories. Only the bench's timed scenarios can show these.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_RD   = 4'b0101,
    CMD_WR   = 4'b0100,
    CMD_REF  = 4'b0001
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROWWAIT,
    ST_ACCGAP,
    ST_REFWAIT
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
  parameter int INTERVAL = 782,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_taken,
  output logic owed_any,
  output logic owed_full
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [CW-1:0] tick_cnt;
  logic [OW-1:0] owed;
  logic          tick;
  logic          inc;

  assign tick = (tick_cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;
  end

  // saturate at the limit unless a refresh leaves in the same cycle
  assign inc = tick && ((owed != OW'(MAX_OWED)) || ref_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else begin
      case ({inc, ref_taken})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign owed_any  = (owed != '0);
  assign owed_full = (owed == OW'(MAX_OWED));
endmodule

// File: rtl/sdr_pin_stage.sv
module sdr_pin_stage
  import sdr_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          cmd_in,
  input  logic [BANK_W-1:0] ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_in;
      ba   <= ba_in;
      addr <= addr_in;
    end
  end
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_seq_pkg::*;
#(
  parameter int BANK_W          = 2,
  parameter int ROW_W           = 12,
  parameter int COL_W           = 8,
  parameter int T_RCD           = 3,
  parameter int T_RAS           = 6,
  parameter int T_RP            = 3,
  parameter int T_DPL           = 2,
  parameter int T_RC            = 9,
  parameter int BURST_LEN       = 4,
  parameter int CLK_PERIOD_PS   = 20000,
  parameter int REF_INTERVAL_PS = 15625000,
  parameter int MAX_OWED        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_addr
);
  localparam int AP_BIT   = 10;
  localparam int RD_GAP   = imax(T_RAS - T_RCD, BURST_LEN) + T_RP;
  localparam int WR_GAP   = imax(T_RAS - T_RCD, BURST_LEN - 1 + T_DPL) + T_RP;
  localparam int REF_CLKS = (REF_INTERVAL_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_WAIT = imax(imax(T_RC, T_RCD), imax(RD_GAP, WR_GAP));
  localparam int TMR_W    = $clog2(MAX_WAIT + 1);

  seq_state_e        state, state_n;
  sdr_cmd_e          cmd_n;
  logic [BANK_W-1:0] ba_n;
  logic [ROW_W-1:0]  addr_n;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              ref_taken;
  logic              owed_any, owed_full;
  logic              accept;

  logic              hold_wr;
  logic [BANK_W-1:0] hold_bank;
  logic [COL_W-1:0]  hold_col;
  logic [ROW_W-1:0]  col_addr;

  sdr_refresh_pacer #(
    .INTERVAL (REF_CLKS),
    .MAX_OWED (MAX_OWED)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_taken (ref_taken),
    .owed_any  (owed_any),
    .owed_full (owed_full)
  );

  sdr_wait_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign req_ready = (state == ST_IDLE) && !owed_full;
  assign accept    = req_valid && req_ready;

  always_comb begin
    col_addr = '0;
    col_addr[COL_W-1:0] = hold_col;
    col_addr[AP_BIT]    = 1'b1;
  end

  always_comb begin
    state_n   = state;
    cmd_n     = CMD_NOP;
    ba_n      = '0;
    addr_n    = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ref_taken = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (owed_any && (owed_full || !req_valid)) begin
          cmd_n     = CMD_REF;
          ref_taken = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(T_RC - 2);
          state_n   = ST_REFWAIT;
        end else if (accept) begin
          cmd_n    = CMD_ACT;
          ba_n     = req_bank;
          addr_n   = req_row;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(T_RCD - 1);
          state_n  = ST_ROWWAIT;
        end
      end
      ST_ROWWAIT: begin
        if (tmr_done) begin
          cmd_n    = hold_wr ? CMD_WR : CMD_RD;
          ba_n     = hold_bank;
          addr_n   = col_addr;
          tmr_load = 1'b1;
          tmr_val  = hold_wr ? TMR_W'(WR_GAP - 2) : TMR_W'(RD_GAP - 2);
          state_n  = ST_ACCGAP;
        end
      end
      ST_ACCGAP, ST_REFWAIT: begin
        if (tmr_done) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_wr   <= 1'b0;
      hold_bank <= '0;
      hold_col  <= '0;
    end else if (accept && (state_n == ST_ROWWAIT)) begin
      hold_wr   <= req_write;
      hold_bank <= req_bank;
      hold_col  <= req_col;
    end
  end

  sdr_pin_stage #(.BANK_W(BANK_W), .ADDR_W(ROW_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_in  (cmd_n),
    .ba_in   (ba_n),
    .addr_in (addr_n),
    .cs_n    (cmd_cs_n),
    .ras_n   (cmd_ras_n),
    .cas_n   (cmd_cas_n),
    .we_n    (cmd_we_n),
    .ba      (cmd_ba),
    .addr    (cmd_addr)
  );
endmodule

// File: rtl/sdr_cmd_seq_chk.sv
module sdr_cmd_seq_chk #(
  parameter int T_RCD  = 3,
  parameter int T_RC   = 9,
  parameter int RD_GAP = 7,
  parameter int WR_GAP = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10
);
  logic [3:0]  pins;
  logic        is_nop, is_act, is_rd, is_wr, is_ref;
  logic [15:0] since_act, since_acc, since_ref;
  logic        last_wr;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (pins == 4'b0111);
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_wr  = (pins == 4'b0100);
  assign is_ref = (pins == 4'b0001);

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF;
      since_acc <= 16'hFFFF;
      since_ref <= 16'hFFFF;
      last_wr   <= 1'b0;
    end else begin
      since_act <= is_act ? 16'd1 : sat_inc(since_act);
      since_acc <= (is_rd || is_wr) ? 16'd1 : sat_inc(since_acc);
      since_ref <= is_ref ? 16'd1 : sat_inc(since_ref);
      if (is_rd || is_wr) last_wr <= is_wr;
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nop || is_act || is_rd || is_wr || is_ref)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> is_nop); // R2
  AST_BUSY_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !req_ready); // R2
  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> (since_act == 16'(T_RCD))); // R3
  AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> a10); // R3
  AST_READ_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_act || is_ref) && !last_wr) |-> (since_acc >= 16'(RD_GAP))); // R4
  AST_WRITE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_act || is_ref) && last_wr) |-> (since_acc >= 16'(WR_GAP))); // R5
  AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref < 16'(T_RC)) |-> is_nop); // R7
endmodule

bind sdr_cmd_seq sdr_cmd_seq_chk #(
  .T_RCD  (T_RCD),
  .T_RC   (T_RC),
  .RD_GAP (RD_GAP),
  .WR_GAP (WR_GAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cs_n      (cmd_cs_n),
  .ras_n     (cmd_ras_n),
  .cas_n     (cmd_cas_n),
  .we_n      (cmd_we_n),
  .a10       (cmd_addr[10])
);

// File: tb/sdr_cmd_seq_test.sv
module sdr_cmd_seq_test;
  localparam int T_RCD    = 3;
  localparam int T_RC     = 9;
  localparam int RD_GAP   = 7;   // max(6-3,4)+3
  localparam int WR_GAP   = 8;   // max(6-3,4-1+2)+3
  localparam int REF_CLKS = 101; // ceil(2_010_000 / 20_000)
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_REF = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;
  logic [3:0]  pins;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  sdr_cmd_seq #(
    .T_RCD(3), .T_RAS(6), .T_RP(3), .T_DPL(2), .T_RC(9), .BURST_LEN(4),
    .CLK_PERIOD_PS(20000), .REF_INTERVAL_PS(2010000), .MAX_OWED(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_ref(input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pins == P_REF) begin
        t = cyc;
        break;
      end
    end
    chk(t >= 0, "R8 refresh seen on idle bus", t, 0);
  endtask

  // R11: reset state
  task automatic t_reset;
    @(negedge clk);
    chk(pins == P_NOP, "R11 NOP after reset", pins, P_NOP);
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
  endtask

  // R1 R2 R3 R4 R5: one closed access
  task automatic t_access(input bit wr, input logic [1:0] bank,
                          input logic [11:0] row, input logic [7:0] col);
    int gap;
    logic [11:0] exp_ca;
    gap    = wr ? WR_GAP : RD_GAP;
    exp_ca = 12'(col) | 12'h400;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = bank; req_row = row; req_col = col;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pins == P_ACT, "R1 R2 ACT code", pins, P_ACT);
    chk(cmd_ba == bank, "R2 ACT bank", cmd_ba, bank);
    chk(cmd_addr == row, "R2 ACT row", cmd_addr, row);
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    for (int k = 1; k < T_RCD; k++) begin
      @(negedge clk);
      chk(pins == P_NOP && !req_ready, "R3 NOP while row opens", pins, P_NOP);
    end
    @(negedge clk);
    chk(pins == (wr ? P_WR : P_RD), "R1 R3 column command after T_RCD", pins, wr ? P_WR : P_RD);
    chk(cmd_ba == bank, "R3 column bank", cmd_ba, bank);
    chk(cmd_addr == exp_ca, "R3 column address with auto-precharge", cmd_addr, exp_ca);
    for (int k = 1; k <= gap - 2; k++) begin
      @(negedge clk);
      chk(pins == P_NOP && !req_ready, wr ? "R5 quiet write recovery" : "R4 quiet read recovery",
          {req_ready, pins}, P_NOP);
    end
    @(negedge clk);
    chk(pins == P_NOP && req_ready, wr ? "R5 ready after write gap" : "R4 ready after read gap",
        req_ready, 1);
  endtask

  // R6 R7 R8: idle refresh pacing
  task automatic t_idle_refresh;
    int t0, t1;
    wait_ref(400, t0);
    for (int k = 1; k < T_RC; k++) begin
      @(negedge clk);
      chk(pins == P_NOP, "R7 NOP after REF", pins, P_NOP);
    end
    wait_ref(400, t1);
    chk(t1 - t0 == REF_CLKS, "R6 R8 idle refresh spacing (rounded up)", t1 - t0, REF_CLKS);
  endtask

  // R9 R7: postponement behind a request stream, then a burst
  task automatic t_postpone;
    int t0, n_stream, n_burst, prev, bad_space;
    n_stream = 0; n_burst = 0; prev = -1; bad_space = 0;
    wait_ref(400, t0);
    while (cyc < t0 + 10) @(negedge clk);
    req_write = 1'b0; req_bank = 2'd2; req_row = 12'h155; req_col = 8'h21;
    req_valid = 1'b1;
    while (cyc < t0 + 525) begin
      @(negedge clk);
      if (pins == P_REF) n_stream++;
    end
    req_valid = 1'b0;
    while (cyc < t0 + 600) begin
      @(negedge clk);
      if (pins == P_REF) begin
        n_burst++;
        if (prev >= 0 && cyc - prev != T_RC) bad_space++;
        prev = cyc;
      end
    end
    chk(n_stream == 0, "R9 no refresh while requests stream", n_stream, 0);
    chk(n_burst == 5, "R9 owed refreshes issued after stream", n_burst, 5);
    chk(bad_space == 0, "R7 back-to-back refresh spacing", bad_space, 0);
  endtask

  // R10: forced refresh at the owed limit
  task automatic t_forced;
    int t0, tref;
    bit prev_ready, ready_before;
    tref = -1; prev_ready = 1'b1; ready_before = 1'b1;
    wait_ref(400, t0);
    while (cyc < t0 + 5) @(negedge clk);
    req_write = 1'b1; req_bank = 2'd1; req_row = 12'h0AA; req_col = 8'h3C;
    req_valid = 1'b1;
    while (cyc < t0 + 900) begin
      @(negedge clk);
      if (pins == P_REF) begin
        tref = cyc;
        ready_before = prev_ready;
        break;
      end
      prev_ready = req_ready;
    end
    req_valid = 1'b0;
    chk(tref >= t0 + 8 * REF_CLKS - 8 && tref <= t0 + 8 * REF_CLKS + 14,
        "R10 refresh forced at owed limit", tref - t0, 8 * REF_CLKS);
    chk(ready_before == 1'b0, "R10 ready low with request waiting", ready_before, 0);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_access(1'b0, 2'd0, 12'h123, 8'h45);
    t_access(1'b1, 2'd3, 12'hFFF, 8'hFF);
    t_access(1'b0, 2'd1, 12'h000, 8'h00);
    t_access(1'b1, 2'd2, 12'h800, 8'h80);
    t_idle_refresh();
    t_postpone();
    t_forced();
    t_access(1'b0, 2'd3, 12'h5A5, 8'h7E);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
  end
endmodule